// File: doc/BRIEF.md
# Bitfield Extract and Mask Unit

This unit carries out the scalar bitfield operations of an integer datapath. Two extract operations, one zero-filling and one sign-filling, pull a field out of a 32-bit data word. The position and width of that field are packed together in one 32-bit control operand. Two mask operations build a contiguous run of ones from a run length and a start position. One of them produces a 32-bit word and the other a 64-bit word.

An operation is presented with a valid strobe, an opcode and two 32-bit sources. One clock later the unit returns a 64-bit destination value, a next condition flag and a write enable for that flag. Extracts update the flag with a non-zero test of their result. Masks never write the flag. Register access and every other ALU operation live outside this block.

Top module: `bfx_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_data, out_flag and out_flag_we are all zero.
- R2: Results are registered with one cycle of latency. A cycle with in_valid low gives out_valid=0 and out_flag_we=0 on the next cycle.
- R3: For both extracts, the offset is in_src_b[4:0] and the length is in_src_b[22:16] (0..127). All other bits of in_src_b have no effect on the result.
- R4: An extract with length 0 returns 0, whatever the offset and data.
- R5: Unsigned extract with offset+length < 32 returns data bits [offset+length-1:offset] at bit 0, with zeros above them.
- R6: Signed extract with offset+length < 32 returns the same field, with every bit above it equal to the top bit of the field.
- R7: When offset+length >= 32 and the length is non-zero, the extract returns the data shifted right by the offset. The shift is logical for the unsigned form and arithmetic for the signed form.
- R8: Every extract drives out_flag_we=1, with out_flag=1 exactly when the 64-bit out_data is non-zero.
- R9: The 32-bit mask returns (2^(in_src_a&31) - 1) shifted left by (in_src_b&31). Bits pushed above bit 31 are dropped.
- R10: The 64-bit mask returns (2^(in_src_a&63) - 1) shifted left by (in_src_b&63) over 64 bits. Bits pushed above bit 63 are dropped, and nothing wraps around.
- R11: Both masks drive out_flag_we=0 and out_flag=0.
- R12: The opcodes are 36 for the 32-bit mask, 37 for the 64-bit mask, 39 for the unsigned extract and 40 for the signed extract. Any other opcode with in_valid gives out_valid=1, out_data=0 and out_flag_we=0.
- R13: Every 32-bit operation (both extracts and the 32-bit mask) returns zero in out_data[63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| in_opcode | input | 6 | Operation code |
| in_src_a | input | 32 | Extract data word, or mask run length |
| in_src_b | input | 32 | Extract control word, or mask start position |
| out_valid | output | 1 | Result of the previous cycle's operation |
| out_data | output | 64 | Destination value |
| out_flag | output | 1 | Next condition flag value |
| out_flag_we | output | 1 | Write enable for the condition flag |

## Verification
The only state is the output register, so a fault there appears one cycle after the operation that caused it. A fault in the decode or the datapath shows up at the ports on the cycle after the strobe. Such a fault can show as a field cut at the wrong boundary, a fill of the wrong polarity above a signed field, or the wrong shift used in the region past bit 31. It can also show as a flag enable raised for a mask, or a flag that disagrees with the data. Directed cases cover a length of zero, offset 31, the point where offset+length is exactly 32, lengths above 32 and mask runs that overflow the word. Random offsets and lengths, compared against an independent shift-based model, cover the rest of the extract space.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int NARROW_W    = 32;
    localparam int WIDE_W      = 64;
    localparam int OPC_W       = 6;
    localparam int CTL_LEN_LSB = 16;
    localparam int CTL_LEN_W   = 7;
    localparam int NARROW_SH_W = $clog2(NARROW_W);
    localparam int WIDE_SH_W   = $clog2(WIDE_W);
    localparam int MASK_VARIANTS = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_MASK_N = 6'd36,
        OP_MASK_W = 6'd37,
        OP_EXT_U  = 6'd39,
        OP_EXT_S  = 6'd40
    } bfx_op_e;

    typedef struct packed {
        logic              valid;
        logic [WIDE_W-1:0] data;
        logic              flag;
        logic              flag_we;
    } bfx_res_t;

    function automatic logic op_is_extract(input logic [OPC_W-1:0] op);
        return (op == OP_EXT_U) || (op == OP_EXT_S);
    endfunction

    function automatic logic op_is_mask(input logic [OPC_W-1:0] op);
        return (op == OP_MASK_N) || (op == OP_MASK_W);
    endfunction

endpackage

// File: rtl/bfx_extract.sv
module bfx_extract #(
    parameter int W       = 32,
    parameter int LEN_LSB = 16,
    parameter int LEN_W   = 7
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] ctl,
    input  logic         sign_fill,
    output logic [W-1:0] field
);
    localparam int SH_W  = $clog2(W);
    localparam int SUM_W = LEN_W + 1;

    logic [SH_W-1:0]  off;
    logic [LEN_W-1:0] len;
    logic [SUM_W-1:0] span;
    logic [W-1:0]     sh_log;
    logic [W-1:0]     sh_ari;
    logic [W-1:0]     shifted;
    logic [W-1:0]     keep;
    logic [SH_W-1:0]  top_idx;
    logic             top_bit;

    assign off     = ctl[SH_W-1:0];
    assign len     = ctl[LEN_LSB +: LEN_W];
    assign span    = SUM_W'(len) + SUM_W'(off);
    assign sh_log  = data >> off;
    assign sh_ari  = $signed(data) >>> off;
    assign shifted = sign_fill ? sh_ari : sh_log;
    // only used in the in-range case, where len < W
    assign keep    = (W'(1) << len[SH_W-1:0]) - W'(1);
    assign top_idx = len[SH_W-1:0] - SH_W'(1);
    assign top_bit = shifted[top_idx];

    always_comb begin
        if (len == '0) begin
            field = '0;
        end else if (span < SUM_W'(W)) begin
            field = shifted & keep;
            if (sign_fill && top_bit) begin
                field = field | ~keep;
            end
        end else begin
            field = shifted;
        end
    end

endmodule

// File: rtl/bfx_mask.sv
module bfx_mask #(
    parameter int W = 32
) (
    input  logic [$clog2(W)-1:0] run_len,
    input  logic [$clog2(W)-1:0] run_pos,
    output logic [W-1:0]         mask
);
    logic [W-1:0] ones;

    assign ones = (W'(1) << run_len) - W'(1);
    assign mask = ones << run_pos;

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [OPC_W-1:0]     in_opcode,
    input  logic [NARROW_W-1:0]  in_src_a,
    input  logic [NARROW_W-1:0]  in_src_b,
    output logic                 out_valid,
    output logic [WIDE_W-1:0]    out_data,
    output logic                 out_flag,
    output logic                 out_flag_we
);
    logic [NARROW_W-1:0] ext_field;
    logic [WIDE_W-1:0]   mask_vec [MASK_VARIANTS];
    bfx_res_t            res_d;
    bfx_res_t            res_q;

    bfx_extract #(
        .W       (NARROW_W),
        .LEN_LSB (CTL_LEN_LSB),
        .LEN_W   (CTL_LEN_W)
    ) u_extract (
        .data      (in_src_a),
        .ctl       (in_src_b),
        .sign_fill (in_opcode == OP_EXT_S),
        .field     (ext_field)
    );

    // variant 0 is the narrow mask, variant 1 the wide one
    for (genvar gi = 0; gi < MASK_VARIANTS; gi++) begin : g_mask
        localparam int MW   = NARROW_W << gi;
        localparam int MSHW = $clog2(MW);
        logic [MW-1:0] m;
        bfx_mask #(.W(MW)) u_mask (
            .run_len (in_src_a[MSHW-1:0]),
            .run_pos (in_src_b[MSHW-1:0]),
            .mask    (m)
        );
        assign mask_vec[gi] = WIDE_W'(m);
    end

    always_comb begin
        res_d         = '0;
        res_d.valid   = in_valid;
        if (in_valid) begin
            if (op_is_extract(in_opcode)) begin
                res_d.data    = WIDE_W'(ext_field);
                res_d.flag    = (ext_field != '0);
                res_d.flag_we = 1'b1;
            end else if (in_opcode == OP_MASK_N) begin
                res_d.data = mask_vec[0];
            end else if (in_opcode == OP_MASK_W) begin
                res_d.data = mask_vec[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_data    = res_q.data;
    assign out_flag    = res_q.flag;
    assign out_flag_we = res_q.flag_we;

endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk
    import bfx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [OPC_W-1:0]    in_opcode,
    input logic [NARROW_W-1:0] in_src_b,
    input logic                out_valid,
    input logic [WIDE_W-1:0]   out_data,
    input logic                out_flag,
    input logic                out_flag_we
);
    logic narrow_op;
    logic known_op;
    assign narrow_op = op_is_extract(in_opcode) || (in_opcode == OP_MASK_N);
    assign known_op  = op_is_extract(in_opcode) || op_is_mask(in_opcode);

    // R2
    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_flag_we));

    // R4
    p_zero_len_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_extract(in_opcode)
         && in_src_b[CTL_LEN_LSB +: CTL_LEN_W] == '0) |=> (out_data == '0));

    // R8
    p_ext_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_extract(in_opcode))
        |=> (out_flag_we && (out_flag == (out_data != '0))));

    // R11
    p_mask_no_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_mask(in_opcode)) |=> (!out_flag_we && !out_flag));

    // R12
    p_unknown_op_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !known_op) |=> (out_valid && out_data == '0 && !out_flag_we));

    // R13
    p_upper_zero_r13: assert property (@(posedge clk) disable iff (rst)
        (in_valid && narrow_op) |=> (out_data[WIDE_W-1:NARROW_W] == '0));

endmodule

bind bfx_unit bfx_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_src_b    (in_src_b),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_flag    (out_flag),
    .out_flag_we (out_flag_we)
);

// File: tb/bfx_unit_test.sv
`timescale 1ns/1ps
module bfx_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_opcode = '0;
    logic [31:0] in_src_a = '0;
    logic [31:0] in_src_b = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_flag;
    logic        out_flag_we;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [5:0] C_MASK32 = 6'd36;
    localparam logic [5:0] C_MASK64 = 6'd37;
    localparam logic [5:0] C_EXTU   = 6'd39;
    localparam logic [5:0] C_EXTS   = 6'd40;

    always #4 clk = ~clk;

    bfx_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .out_valid(out_valid),
        .out_data(out_data), .out_flag(out_flag), .out_flag_we(out_flag_we)
    );

    // reference model: shift the field to the top, then back down
    function automatic logic [63:0] ref_ext(input logic [31:0] a, input logic [31:0] b,
                                            input bit sgn);
        int unsigned off = b[4:0];
        int unsigned len = b[22:16];
        logic [31:0] t;
        logic [31:0] r;
        if (len == 0) begin
            r = '0;
        end else if (off + len < 32) begin
            t = a << (32 - off - len);
            if (sgn) r = $signed(t) >>> (32 - len);
            else     r = t >> (32 - len);
        end else begin
            if (sgn) r = $signed(a) >>> off;
            else     r = a >> off;
        end
        return {32'h0, r};
    endfunction

    // reference model: set each bit that falls inside the run
    function automatic logic [63:0] ref_mask(input int w, input logic [31:0] a,
                                             input logic [31:0] b);
        int unsigned len = a & (w - 1);
        int unsigned pos = b & (w - 1);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w && i >= pos && i < pos + len) r[i] = 1'b1;
        end
        return r;
    endfunction

    task automatic compare(input logic ev, input logic [63:0] ed, input logic ewe,
                           input logic ef, input string tag);
        checks++;
        if (out_valid !== ev || out_data !== ed || out_flag_we !== ewe || out_flag !== ef) begin
            errors++;
            $display("FAIL %s: got v=%0b d=%h we=%0b f=%0b, expected v=%0b d=%h we=%0b f=%0b",
                     tag, out_valid, out_data, out_flag_we, out_flag, ev, ed, ewe, ef);
        end
    endtask

    task automatic run_op(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] ed, input logic ewe, input logic ef,
                          input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_opcode = op;
        in_src_a  = a;
        in_src_b  = b;
        @(negedge clk);
        compare(1'b1, ed, ewe, ef, tag);
        in_valid = 1'b0;
    endtask

    task automatic run_ext(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                           input string tag);
        logic [63:0] e = ref_ext(a, b, sgn);
        run_op(sgn ? C_EXTS : C_EXTU, a, b, e, 1'b1, e != 0, tag);
    endtask

    task automatic run_mask(input int w, input logic [31:0] a, input logic [31:0] b,
                            input string tag);
        run_op(w == 32 ? C_MASK32 : C_MASK64, a, b, ref_mask(w, a, b), 1'b0, 1'b0, tag);
    endtask

    function automatic logic [31:0] ctl(input int off, input int len);
        return {9'h0, 7'(len), 11'h0, 5'(off)};
    endfunction

    task automatic t_reset;
        rst = 1'b1;
        in_valid = 1'b1;
        in_opcode = C_EXTS;
        in_src_a = 32'hFFFF_FFFF;
        in_src_b = ctl(0, 8);
        repeat (3) @(negedge clk);
        compare(1'b0, 64'h0, 1'b0, 1'b0, "R1 during reset");
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(1'b0, 64'h0, 1'b0, 1'b0, "R1 first cycle after reset");
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0;
        in_opcode = C_EXTU;
        in_src_a = 32'hFFFF_FFFF;
        in_src_b = ctl(0, 4);
        @(negedge clk);
        compare(1'b0, 64'h0, 1'b0, 1'b0, "R2 idle cycle writes nothing");
    endtask

    task automatic t_ext_directed;
        run_op(C_EXTU, 32'hDEAD_BEEF, ctl(7, 0), 64'h0, 1'b1, 1'b0, "R4 zero length unsigned");
        run_op(C_EXTS, 32'hFFFF_FFFF, ctl(31, 0), 64'h0, 1'b1, 1'b0, "R4 zero length signed");
        run_op(C_EXTU, 32'h0000_0A50, ctl(4, 8), 64'hA5, 1'b1, 1'b1, "R5 unsigned field");
        run_op(C_EXTS, 32'h0000_0A50, ctl(4, 8), 64'hFFFF_FFA5, 1'b1, 1'b1, "R6 signed negative field");
        run_op(C_EXTS, 32'h0000_0A50, ctl(4, 4), 64'h5, 1'b1, 1'b1, "R6 signed positive field");
        run_op(C_EXTU, 32'h0000_0A50, ctl(0, 4), 64'h0, 1'b1, 1'b0, "R8 zero result clears flag");
        // offset 31, length 1: sum is exactly 32
        run_op(C_EXTU, 32'h8000_0000, ctl(31, 1), 64'h1, 1'b1, 1'b1, "R7 offset 31 unsigned");
        run_op(C_EXTS, 32'h8000_0000, ctl(31, 1), 64'hFFFF_FFFF, 1'b1, 1'b1, "R7 offset 31 signed");
        run_op(C_EXTU, 32'h8000_00F0, ctl(4, 40), 64'h0800_000F, 1'b1, 1'b1, "R7 long length logical");
        run_op(C_EXTS, 32'h8000_00F0, ctl(4, 40), 64'hF800_000F, 1'b1, 1'b1, "R7 long length arithmetic");
        run_op(C_EXTS, 32'h8000_00F0, ctl(0, 127), 64'h8000_00F0, 1'b1, 1'b1, "R7 length 127");
        run_op(C_EXTS, 32'h7000_0000, ctl(28, 3), 64'hFFFF_FFFF, 1'b1, 1'b1, "R6 sum 31 signed");
        // stray control bits outside [4:0] and [22:16] must not matter
        run_op(C_EXTU, 32'h0000_0A50, ctl(4, 8) | 32'hFF80_FFE0, 64'hA5, 1'b1, 1'b1,
               "R3 stray control bits ignored");
        run_op(C_EXTS, 32'h0000_0A50, ctl(4, 8) | 32'hFF80_FFE0, 64'hFFFF_FFA5, 1'b1, 1'b1,
               "R3 stray control bits ignored signed");
    endtask

    task automatic t_ext_random;
        logic [31:0] a;
        logic [31:0] b;
        for (int i = 0; i < 400; i++) begin
            a = $urandom;
            b = $urandom;
            if (i % 4 == 0) b[22:16] = 7'($urandom_range(0, 33));
            if (i % 16 == 1) b[4:0] = 5'd31;
            run_ext(i[0], a, b, "R5 R6 R7 R8 R13 random extract");
        end
    endtask

    task automatic t_mask32;
        run_op(C_MASK32, 32'd0, 32'd5, 64'h0, 1'b0, 1'b0, "R9 zero length mask");
        run_op(C_MASK32, 32'd8, 32'd4, 64'hFF0, 1'b0, 1'b0, "R9 R11 byte mask");
        run_op(C_MASK32, 32'd31, 32'd31, 64'h8000_0000, 1'b0, 1'b0, "R9 R13 overflow dropped");
        run_op(C_MASK32, 32'hFFFF_FFE4, 32'hFFFF_FFE0, 64'hF, 1'b0, 1'b0, "R9 high source bits ignored");
        for (int i = 0; i < 100; i++) begin
            run_mask(32, $urandom, $urandom, "R9 R11 random mask32");
        end
    endtask

    task automatic t_mask64;
        run_op(C_MASK64, 32'd63, 32'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, "R10 63-bit run");
        run_op(C_MASK64, 32'd16, 32'd56, 64'hFF00_0000_0000_0000, 1'b0, 1'b0, "R10 no wraparound");
        run_op(C_MASK64, 32'd40, 32'd8, 64'h0000_FFFF_FFFF_FF00, 1'b0, 1'b0, "R10 run across halves");
        run_op(C_MASK64, 32'hFFFF_FFC2, 32'h0000_0041, 64'h6, 1'b0, 1'b0, "R10 high source bits ignored");
        for (int i = 0; i < 100; i++) begin
            run_mask(64, $urandom, $urandom, "R10 R11 random mask64");
        end
    endtask

    task automatic t_bad_opcode;
        run_op(6'd38, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0, 1'b0, 1'b0, "R12 unused opcode 38");
        run_op(6'd0, 32'h1234_5678, ctl(0, 8), 64'h0, 1'b0, 1'b0, "R12 unused opcode 0");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        t_reset;
        t_idle;
        t_ext_directed;
        t_ext_random;
        t_mask32;
        t_mask64;
        t_bad_opcode;
        t_idle;
        finish_run;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run;
    end

endmodule